// File: doc/BRIEF.md
# In-Flight Memory Request Tracker

This block sits between a processor-side request port and a cache controller and keeps a record of every memory request still in flight. Each request is classified from its attributes into a tracking type and a type sent to the cache. Read-class requests go into one small associative table and write-class requests into another; both tables are keyed by the cache-line address. A request is refused when capacity is exhausted, or reported as aliased when another request to the same line is already outstanding. Otherwise it is issued to the cache with the latency of the cache it targets.

Completion responses name a line and a table. The matching entry is freed and the number of cycles it spent in flight is reported. Four stall counters record which kind of conflict caused each alias. A periodic watchdog raises a sticky deadlock flag when a request has been outstanding for too long.

The response to a request and the result of a completion are combinational in the cycle they are presented. Table contents, counters and flags change at the following clock edge.

Top module: `req_tracker`

## Requirements
- R1: A request gets status FULL (2) when the outstanding count is at or above MAX_OUT, or when its target table has no free entry. FULL takes precedence over aliasing, and a FULL request changes no stall counter.
- R2: Load and instruction fetch are read-class. Every other request kind is write-class: store, store-check read, load-linked, store-conditional, locked read, locked write and flush. A completion is matched only in the table of its own class (cmp_write=1 selects the write table).
- R3: A write-class request whose line is outstanding in either table gets status ALIAS (1) and is not inserted.
- R4: A read-class request whose line is outstanding in either table gets status ALIAS (1) and is not inserted. A request with neither conflict gets status ISSUED (0), and iss_valid is raised.
- R5: Each alias increments exactly one counter. A write-class request blocked by the read table increments stall_st_ld. A write-class request blocked only by the write table increments stall_st_st. A read-class request blocked by the write table increments stall_ld_st. A read-class request blocked only by the read table increments stall_ld_ld.
- R6: A completion that matches reports cmp_hit=1 and frees the entry. cmp_latency equals the completion cycle minus the insertion cycle, so a completion in the cycle right after insertion reports 1.
- R7: A completion whose line is absent from the selected table raises cmp_err for that cycle and leaves the tables unchanged.
- R8: The watchdog is armed by the first insertion and checks every THRESH cycles while anything is outstanding. If any entry is THRESH or more cycles old at a check, deadlock is set and stays set until reset. With the watchdog idle, an insertion in cycle a makes deadlock visible in cycle a+THRESH+1 if the entry is never completed.
- R9: iss_type carries the cache-side type. The encodings are load 0, fetch 1, store 2, atomic 3 and flush 4. Load-linked and store-conditional are sent as atomic. Locked reads and writes are sent as store. A read with the store-check attribute is sent as store. Plain store, flush, load and fetch are sent as themselves.
- R10: iss_lat is IC_LAT when iss_type is fetch, and DC_LAT otherwise.
- R11: out_cnt always equals the read-table occupancy plus the write-table occupancy. It is 0 after reset, together with all stall counters and deadlock.
- R12: The line address is req_addr with its low LINE_OFS bits dropped. Two addresses in the same line alias; addresses in different lines do not.
- R13: One request and one completion may occur in the same cycle. The request is judged against the table state from before the completion, so a request to the line being completed still aliases. out_cnt then changes by the number inserted minus the number freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | Request writes |
| req_flush | input | 1 | Request is a flush (when not a write) |
| req_ifetch | input | 1 | Read is an instruction fetch |
| req_llsc | input | 1 | Load-linked / store-conditional |
| req_locked | input | 1 | Locked read-modify-write access |
| req_stchk | input | 1 | Read carries the store-check attribute |
| rsp_status | output | 2 | 0 issued, 1 aliased, 2 full |
| iss_valid | output | 1 | Request is issued to the cache |
| iss_addr | output | ADDR_W | Address sent to the cache |
| iss_type | output | 3 | Cache-side request type |
| iss_lat | output | LAT_W | Cache lookup latency for the issue |
| cmp_valid | input | 1 | Completion present this cycle |
| cmp_write | input | 1 | Completion targets the write table |
| cmp_line | input | ADDR_W-LINE_OFS | Line address being completed |
| cmp_hit | output | 1 | Completion matched an entry |
| cmp_err | output | 1 | Completion matched nothing |
| cmp_latency | output | TIME_W | Cycles the completed request was in flight |
| out_cnt | output | OUT_W | Outstanding request count |
| stall_st_ld | output | CNT_W | Write-class blocked by read |
| stall_st_st | output | CNT_W | Write-class blocked by write |
| stall_ld_st | output | CNT_W | Read-class blocked by write |
| stall_ld_ld | output | CNT_W | Read-class blocked by read |
| deadlock | output | 1 | Sticky watchdog flag |

## Verification
A lost or duplicated table entry shows at the ports in the very next request or completion to that line. It appears as a spurious ALIAS, a missing alias, or a cmp_err where cmp_hit is expected. A drifting outstanding count shows as a wrong out_cnt one cycle later, and as FULL arriving too early or too late. A misread issue time shows directly in cmp_latency, and a broken watchdog counter moves the deadlock flag off its exact cycle of THRESH+1 after a lone insertion.

// File: rtl/rqt_pkg.sv
package rqt_pkg;

  typedef enum logic [3:0] {
    P_LD, P_IFETCH, P_ST, P_RMW_RD, P_RMW_WR,
    P_LL, P_SC, P_LK_RD, P_LK_WR, P_FLUSH
  } prim_e;

  typedef enum logic [2:0] {
    S_LD = 3'd0, S_IFETCH = 3'd1, S_ST = 3'd2, S_ATOMIC = 3'd3, S_FLUSH = 3'd4
  } sec_e;

  typedef enum logic [1:0] {
    RS_ISSUED = 2'd0, RS_ALIAS = 2'd1, RS_FULL = 2'd2
  } rsp_e;

endpackage

// File: rtl/rqt_classify.sv
module rqt_classify
  import rqt_pkg::*;
(
  input  logic is_write,
  input  logic is_flush,
  input  logic ifetch,
  input  logic llsc,
  input  logic locked,
  input  logic stchk,
  output logic wr_class,
  output sec_e sec
);

  prim_e prim;

  always_comb begin
    if (llsc) begin
      prim = is_write ? P_SC : P_LL;
      sec  = S_ATOMIC;
    end else if (locked) begin
      prim = is_write ? P_LK_WR : P_LK_RD;
      sec  = S_ST;
    end else if (is_write) begin
      prim = P_ST;
      sec  = S_ST;
    end else if (is_flush) begin
      prim = P_FLUSH;
      sec  = S_FLUSH;
    end else if (ifetch) begin
      prim = P_IFETCH;
      sec  = S_IFETCH;
    end else if (stchk) begin
      prim = P_RMW_RD;
      sec  = S_ST;
    end else begin
      prim = P_LD;
      sec  = S_LD;
    end
  end

  assign wr_class = !(prim == P_LD || prim == P_IFETCH);

endmodule

// File: rtl/rqt_table.sv
module rqt_table #(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 26,
  parameter int TIME_W = 16,
  parameter int THRESH = 64,
  parameter int OCC_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] look_line,
  input  logic              ins_en,
  input  logic              rm_en,
  input  logic [LINE_W-1:0] rm_line,
  input  logic [TIME_W-1:0] now,
  output logic              look_hit,
  output logic              rm_hit,
  output logic [TIME_W-1:0] rm_age,
  output logic [OCC_W-1:0]  occ,
  output logic              full,
  output logic              any_old
);

  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [LINE_W-1:0] line_q [DEPTH];
  logic [TIME_W-1:0] t_q    [DEPTH];
  logic [DEPTH-1:0]  lk_m, rm_m, old_m, free_sel;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign lk_m[i]  = vld_q[i] && (line_q[i] == look_line);
    assign rm_m[i]  = vld_q[i] && (line_q[i] == rm_line);
    assign old_m[i] = vld_q[i] && ((now - t_q[i]) >= TIME_W'(THRESH));

    always_ff @(posedge clk) begin
      if (ins_en && free_sel[i]) begin
        line_q[i] <= look_line;
        t_q[i]    <= now;
      end
    end
  end

  always_comb begin
    logic taken;
    taken    = 1'b0;
    free_sel = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !taken) begin
        free_sel[i] = 1'b1;
        taken       = 1'b1;
      end
    end
  end

  always_comb begin
    rm_age = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rm_m[i]) rm_age = now - t_q[i];
    end
  end

  assign look_hit = |lk_m;
  assign rm_hit   = |rm_m;
  assign full     = &vld_q;
  assign any_old  = |old_m;
  assign occ      = OCC_W'($countones(vld_q));

  always_comb begin
    vld_d = vld_q;
    if (rm_en)  vld_d = vld_d & ~rm_m;
    if (ins_en) vld_d = vld_d | free_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // R3
  ins_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> (!look_hit && !full));

  // R12
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_m));

endmodule

// File: rtl/rqt_watchdog.sv
module rqt_watchdog #(
  parameter int THRESH = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic busy_next,
  input  logic any_old,
  output logic deadlock
);

  localparam int CW = (THRESH > 2) ? $clog2(THRESH) : 1;

  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          dl_q, dl_d;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    dl_d    = dl_q;
    if (!armed_q) begin
      if (start) armed_d = 1'b1;
      cnt_d = '0;
    end else if (cnt_q == CW'(THRESH - 1)) begin
      cnt_d   = '0;
      armed_d = busy_next;
      if (any_old) dl_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      dl_q    <= 1'b0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      dl_q    <= dl_d;
    end
  end

  assign deadlock = dl_q;

  // R8
  deadlock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock |=> deadlock);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !deadlock) |=> !deadlock);

endmodule

// File: rtl/req_tracker.sv
module req_tracker
  import rqt_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFS = 6,
  parameter int RD_DEPTH = 8,
  parameter int WR_DEPTH = 8,
  parameter int MAX_OUT  = 12,
  parameter int TIME_W   = 16,
  parameter int THRESH   = 64,
  parameter int CNT_W    = 16,
  parameter int LAT_W    = 8,
  parameter int IC_LAT   = 2,
  parameter int DC_LAT   = 3,
  localparam int LINE_W  = ADDR_W - LINE_OFS,
  localparam int OUT_W   = $clog2(RD_DEPTH + WR_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_flush,
  input  logic              req_ifetch,
  input  logic              req_llsc,
  input  logic              req_locked,
  input  logic              req_stchk,
  output logic [1:0]        rsp_status,
  output logic              iss_valid,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [2:0]        iss_type,
  output logic [LAT_W-1:0]  iss_lat,
  input  logic              cmp_valid,
  input  logic              cmp_write,
  input  logic [LINE_W-1:0] cmp_line,
  output logic              cmp_hit,
  output logic              cmp_err,
  output logic [TIME_W-1:0] cmp_latency,
  output logic [OUT_W-1:0]  out_cnt,
  output logic [CNT_W-1:0]  stall_st_ld,
  output logic [CNT_W-1:0]  stall_st_st,
  output logic [CNT_W-1:0]  stall_ld_st,
  output logic [CNT_W-1:0]  stall_ld_ld,
  output logic              deadlock
);

  logic [LINE_W-1:0] req_line;
  logic              wr_cls;
  sec_e              sec;
  logic              rd_hit, wr_hit, rd_full, wr_full;
  logic              rd_rm_hit, wr_rm_hit, rd_old, wr_old;
  logic [TIME_W-1:0] rd_age, wr_age, now_q;
  logic [OUT_W-1:0]  rd_occ, wr_occ, out_q, out_d;
  logic              cap_full, aliased, accept;
  logic              rd_ins, wr_ins, rd_rm, wr_rm;
  logic [CNT_W-1:0]  c_stld_q, c_stst_q, c_ldst_q, c_ldld_q;
  logic [CNT_W-1:0]  c_stld_d, c_stst_d, c_ldst_d, c_ldld_d;
  logic [CNT_W-1:0]  stall_sum;

  assign req_line = req_addr[ADDR_W-1:LINE_OFS];

  rqt_classify u_cls (
    .is_write (req_write),
    .is_flush (req_flush),
    .ifetch   (req_ifetch),
    .llsc     (req_llsc),
    .locked   (req_locked),
    .stchk    (req_stchk),
    .wr_class (wr_cls),
    .sec      (sec)
  );

  rqt_table #(.DEPTH(RD_DEPTH), .LINE_W(LINE_W), .TIME_W(TIME_W),
              .THRESH(THRESH), .OCC_W(OUT_W)) u_rd_tab (
    .clk (clk), .rst_n (rst_n), .look_line (req_line), .ins_en (rd_ins),
    .rm_en (rd_rm), .rm_line (cmp_line), .now (now_q),
    .look_hit (rd_hit), .rm_hit (rd_rm_hit), .rm_age (rd_age),
    .occ (rd_occ), .full (rd_full), .any_old (rd_old)
  );

  rqt_table #(.DEPTH(WR_DEPTH), .LINE_W(LINE_W), .TIME_W(TIME_W),
              .THRESH(THRESH), .OCC_W(OUT_W)) u_wr_tab (
    .clk (clk), .rst_n (rst_n), .look_line (req_line), .ins_en (wr_ins),
    .rm_en (wr_rm), .rm_line (cmp_line), .now (now_q),
    .look_hit (wr_hit), .rm_hit (wr_rm_hit), .rm_age (wr_age),
    .occ (wr_occ), .full (wr_full), .any_old (wr_old)
  );

  // request side: capacity first, then aliasing
  assign cap_full = (out_q >= OUT_W'(MAX_OUT)) || (wr_cls ? wr_full : rd_full);
  assign aliased  = rd_hit || wr_hit;
  assign accept   = req_valid && !cap_full && !aliased;
  assign rd_ins   = accept && !wr_cls;
  assign wr_ins   = accept && wr_cls;

  always_comb begin
    if (!req_valid)    rsp_status = RS_ISSUED;
    else if (cap_full) rsp_status = RS_FULL;
    else if (aliased)  rsp_status = RS_ALIAS;
    else               rsp_status = RS_ISSUED;
  end

  assign iss_valid = accept;
  assign iss_addr  = req_addr;
  assign iss_type  = sec;
  assign iss_lat   = (sec == S_IFETCH) ? LAT_W'(IC_LAT) : LAT_W'(DC_LAT);

  // completion side
  assign rd_rm       = cmp_valid && !cmp_write;
  assign wr_rm       = cmp_valid && cmp_write;
  assign cmp_hit     = (rd_rm && rd_rm_hit) || (wr_rm && wr_rm_hit);
  assign cmp_err     = cmp_valid && !cmp_hit;
  assign cmp_latency = !cmp_hit ? '0 : (cmp_write ? wr_age : rd_age);

  assign out_d = out_q + OUT_W'(accept) - OUT_W'(cmp_hit);

  // stall counters, one increment per alias
  always_comb begin
    c_stld_d = c_stld_q;
    c_stst_d = c_stst_q;
    c_ldst_d = c_ldst_q;
    c_ldld_d = c_ldld_q;
    if (req_valid && !cap_full) begin
      if (wr_cls) begin
        if (rd_hit)      c_stld_d = c_stld_q + 1'b1;
        else if (wr_hit) c_stst_d = c_stst_q + 1'b1;
      end else begin
        if (wr_hit)      c_ldst_d = c_ldst_q + 1'b1;
        else if (rd_hit) c_ldld_d = c_ldld_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q    <= '0;
      out_q    <= '0;
      c_stld_q <= '0;
      c_stst_q <= '0;
      c_ldst_q <= '0;
      c_ldld_q <= '0;
    end else begin
      now_q    <= now_q + 1'b1;
      out_q    <= out_d;
      c_stld_q <= c_stld_d;
      c_stst_q <= c_stst_d;
      c_ldst_q <= c_ldst_d;
      c_ldld_q <= c_ldld_d;
    end
  end

  rqt_watchdog #(.THRESH(THRESH)) u_wd (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .busy_next (out_d != '0),
    .any_old   (rd_old || wr_old),
    .deadlock  (deadlock)
  );

  assign out_cnt     = out_q;
  assign stall_st_ld = c_stld_q;
  assign stall_st_st = c_stst_q;
  assign stall_ld_st = c_ldst_q;
  assign stall_ld_ld = c_ldld_q;
  assign stall_sum   = c_stld_q + c_stst_q + c_ldst_q + c_ldld_q;

  // R11
  occ_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_q == OUT_W'(rd_occ + wr_occ));

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_q <= OUT_W'(MAX_OUT));

  // R5
  stall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_status == RS_ALIAS) |=> stall_sum == $past(stall_sum) + 1'b1);

  // R13
  accept_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !cmp_hit) |=> out_cnt == $past(out_cnt) + 1'b1);

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_err && !iss_valid) |=> out_cnt == $past(out_cnt));

endmodule

// File: tb/req_tracker_test.sv
module req_tracker_test;

  localparam int ADDR_W = 12, LINE_OFS = 4, RDD = 4, WRD = 4, MAXO = 6;
  localparam int TW = 12, TH = 16, CW = 8, LW = 4, ICL = 2, DCL = 5;
  localparam int LINE_W = ADDR_W - LINE_OFS;
  localparam int OUT_W = $clog2(RDD + WRD + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid, req_write, req_flush, req_ifetch, req_llsc, req_locked, req_stchk;
  logic [ADDR_W-1:0] req_addr;
  logic [1:0] rsp_status;
  logic iss_valid;
  logic [ADDR_W-1:0] iss_addr;
  logic [2:0] iss_type;
  logic [LW-1:0] iss_lat;
  logic cmp_valid, cmp_write, cmp_hit, cmp_err;
  logic [LINE_W-1:0] cmp_line;
  logic [TW-1:0] cmp_latency;
  logic [OUT_W-1:0] out_cnt;
  logic [CW-1:0] s_stld, s_stst, s_ldst, s_ldld;
  logic deadlock;

  int n_chk = 0, n_fail = 0;
  int exp_c [4];  // 0 st_ld, 1 st_st, 2 ld_st, 3 ld_ld

  always #2 clk = ~clk;

  req_tracker #(.ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS), .RD_DEPTH(RDD), .WR_DEPTH(WRD),
    .MAX_OUT(MAXO), .TIME_W(TW), .THRESH(TH), .CNT_W(CW), .LAT_W(LW),
    .IC_LAT(ICL), .DC_LAT(DCL)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_flush(req_flush), .req_ifetch(req_ifetch),
    .req_llsc(req_llsc), .req_locked(req_locked), .req_stchk(req_stchk),
    .rsp_status(rsp_status), .iss_valid(iss_valid), .iss_addr(iss_addr),
    .iss_type(iss_type), .iss_lat(iss_lat), .cmp_valid(cmp_valid),
    .cmp_write(cmp_write), .cmp_line(cmp_line), .cmp_hit(cmp_hit),
    .cmp_err(cmp_err), .cmp_latency(cmp_latency), .out_cnt(out_cnt),
    .stall_st_ld(s_stld), .stall_st_st(s_stst), .stall_ld_st(s_ldst),
    .stall_ld_ld(s_ldld), .deadlock(deadlock));

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic clr();
    req_valid = 0; req_addr = '0; req_write = 0; req_flush = 0; req_ifetch = 0;
    req_llsc = 0; req_locked = 0; req_stchk = 0;
    cmp_valid = 0; cmp_write = 0; cmp_line = '0;
  endtask

  task automatic step();
    @(posedge clk); #1; clr();
  endtask

  task automatic do_reset();
    clr(); rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int k = 0; k < 4; k++) exp_c[k] = 0;
  endtask

  task automatic set_req(input int addr, input bit w);
    req_valid = 1; req_addr = ADDR_W'(addr); req_write = w;
  endtask

  task automatic set_cmp(input int line, input bit w);
    cmp_valid = 1; cmp_line = LINE_W'(line); cmp_write = w;
  endtask

  task automatic chk_stalls(input string r);
    chk({r, " st_ld"}, s_stld, exp_c[0]);
    chk({r, " st_st"}, s_stst, exp_c[1]);
    chk({r, " ld_st"}, s_ldst, exp_c[2]);
    chk({r, " ld_ld"}, s_ldld, exp_c[3]);
  endtask

  // expected cache-side type from the R9 rules
  function automatic int exp_sec(input bit w, f, i, ll, lk, sc);
    if (ll) return 3;
    if (lk) return 2;
    if (w) return 2;
    if (f) return 4;
    if (i) return 1;
    if (sc) return 2;
    return 0;
  endfunction

  function automatic bit exp_wr(input bit w, f, i, ll, lk, sc);
    return ll || lk || w || f || (!i && sc);
  endfunction

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R11 reset state
    #1;
    chk("R11 reset out_cnt", out_cnt, 0);
    chk_stalls("R11 reset");
    chk("R11 reset deadlock", deadlock, 0);
    chk("R4 idle iss_valid", iss_valid, 0);

    // R2 R9 R10 sweep over all attribute combinations
    for (int c = 0; c < 64; c++) begin
      bit w, f, i, ll, lk, sc, ew;
      int es;
      {w, f, i, ll, lk, sc} = 6'(c);
      es = exp_sec(w, f, i, ll, lk, sc);
      ew = exp_wr(w, f, i, ll, lk, sc);
      set_req((c << LINE_OFS) | 3, w);
      req_flush = f; req_ifetch = i; req_llsc = ll; req_locked = lk; req_stchk = sc;
      #1;
      chk("R4 sweep status", rsp_status, 0);
      chk("R9 sweep iss_type", iss_type, es);
      chk("R10 sweep iss_lat", iss_lat, (es == 1) ? ICL : DCL);
      step();
      set_cmp(c, ew);
      #1;
      chk("R2 sweep class hit", cmp_hit, 1);
      chk("R6 sweep latency", cmp_latency, 1);
      step();
      #1;
      chk("R11 sweep drained", out_cnt, 0);
    end

    // R6 latency over several wait lengths
    for (int n = 0; n < 11; n++) begin
      set_req(32'h200, 0);
      step();
      repeat (n) step();
      set_cmp(32'h20, 0);
      #1;
      chk("R6 latency", cmp_latency, n + 1);
      step();
    end

    // R3 R4 R5 R12 alias sweep over class pairs
    for (int c1 = 0; c1 < 2; c1++) begin
      for (int c2 = 0; c2 < 2; c2++) begin
        set_req(32'h330, c1[0]);
        step();
        set_req(32'h339, c2[0]);
        #1;
        chk(c2 ? "R3 alias status" : "R4 alias status", rsp_status, 1);
        chk("R12 alias no issue", iss_valid, 0);
        step();
        if (c2 == 1) exp_c[c1 == 0 ? 0 : 1]++;
        else         exp_c[c1 == 1 ? 2 : 3]++;
        #1;
        chk_stalls("R5 alias");
        chk("R3 alias not inserted", out_cnt, 1);
        set_req(32'h340, c2[0]);
        #1;
        chk("R12 other line issued", rsp_status, 0);
        step();
        set_cmp(32'h33, c1[0]); step();
        set_cmp(32'h34, c2[0]); step();
        #1;
        chk("R11 alias drained", out_cnt, 0);
      end
    end

    // R1 capacity
    for (int k = 0; k < 4; k++) begin
      set_req(32'h400 + k * 16, 1); step();
    end
    set_req(32'h440, 1);
    #1;
    chk("R1 write table full", rsp_status, 2);
    step();
    set_req(32'h405, 1);
    #1;
    chk("R1 full before alias", rsp_status, 2);
    step();
    #1;
    chk_stalls("R1 full no stall");
    set_req(32'h500, 0); step();
    set_req(32'h510, 0); step();
    #1;
    chk("R1 count at max", out_cnt, 6);
    set_req(32'h520, 0);
    #1;
    chk("R1 count cap", rsp_status, 2);
    step();
    for (int k = 0; k < 4; k++) begin
      set_cmp(32'h40 + k, 1); step();
    end
    set_cmp(32'h50, 0); step();
    set_cmp(32'h51, 0); step();
    #1;
    chk("R11 full drained", out_cnt, 0);
    for (int k = 0; k < 4; k++) begin
      set_req(32'h600 + k * 16, 0); step();
    end
    set_req(32'h640, 0);
    #1;
    chk("R1 read table full", rsp_status, 2);
    step();
    for (int k = 0; k < 4; k++) begin
      set_cmp(32'h60 + k, 0); step();
    end

    // R7 absent and wrong-table completions
    set_cmp(32'h77, 0);
    #1;
    chk("R7 absent err", cmp_err, 1);
    chk("R7 absent hit", cmp_hit, 0);
    step();
    set_req(32'h600, 1); step();
    set_cmp(32'h60, 0);
    #1;
    chk("R2 wrong table err", cmp_err, 1);
    step();
    #1;
    chk("R7 count kept", out_cnt, 1);

    // R13 same-cycle completion and request to one line
    set_cmp(32'h60, 1);
    set_req(32'h604, 1);
    #1;
    chk("R13 pre-state alias", rsp_status, 1);
    chk("R13 completion hit", cmp_hit, 1);
    step();
    exp_c[1]++;
    #1;
    chk("R13 count after", out_cnt, 0);
    chk_stalls("R13 stall");
    set_req(32'h620, 0); step();
    set_cmp(32'h62, 0);
    set_req(32'h630, 0);
    #1;
    chk("R13 parallel issue", rsp_status, 0);
    step();
    #1;
    chk("R13 count kept", out_cnt, 1);
    set_cmp(32'h63, 0); step();

    // R8 no flag when every request completes early
    do_reset();
    for (int k = 0; k < 4; k++) begin
      set_req(32'h100, 0); step();
      repeat (TH - 2) step();
      set_cmp(32'h10, 0); step();
    end
    repeat (TH) step();
    #1;
    chk("R8 no false deadlock", deadlock, 0);

    // R8 exact flag cycle for a stuck request
    do_reset();
    set_req(32'h100, 0); step();
    repeat (TH - 1) step();
    #1;
    chk("R8 not yet", deadlock, 0);
    step();
    #1;
    chk("R8 flagged", deadlock, 1);
    set_cmp(32'h10, 0); step();
    repeat (TH + 2) step();
    #1;
    chk("R8 sticky", deadlock, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule